// File: doc/BRIEF.md
# Shunt Section Switching Sequencer

This block is the coarse digital loop of a sectioned solar-array shunt regulator. It receives two asynchronous comparator flags from the analog shunt: one says the shunt current is above its upper limit, the other says it is below its lower limit. It keeps a control word in which each bit turns one switched array section off (bit = 1) or on (bit = 0). One further section is tied to the bus permanently and has no bit.

Each accepted event moves the word by exactly one section. The word is a thermometer code that a shift register updates. The new word reaches the output only on a rising edge of a slow timing clock. The block accepts nothing further until the falling edge that follows. This spacing gives the analog shunt and the bus capacitance time to settle before the next decision. The slow clock comes either from an input pin, passed through a synchronizer, or from an internal divider of the fast clock.

Top module: `shunt_step_sequencer`

## Requirements
- R1: After reset the control word is all ones (every switched section off), busy is low, and no flag has been taken.
- R2: An accepted event with the above-limit flag set shifts the word one place toward the MSB and fills the LSB with 1, which switches one more section off.
- R3: An accepted event with only the below-limit flag set shifts the word one place toward the LSB and fills the MSB with 0, which switches one more section on.
- R4: When both flags are seen at acceptance, the above-limit rule of R2 applies.
- R5: The word stays a thermometer code (0, 1, 3, 7 for three sections). A removal at all-ones leaves all ones, and an addition at zero leaves zero.
- R6: A pending word is written only on a rising edge of the slow clock. If the slow clock is high at acceptance, the write waits for a low phase and then the next rising edge.
- R7: Busy rises at acceptance and stays high until the first slow-clock falling edge after the write. No further event is taken in that time, even if a flag stays asserted, so at most one step happens per slow period.
- R8: Slow-clock edges while neither flag is set leave the word unchanged and busy low.
- R9: With the internal divider selected, the slow clock toggles every HALF_DIV fast cycles, and writes still land in its high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| over_max_i | input | 1 | asynchronous flag: shunt current above upper limit |
| under_min_i | input | 1 | asynchronous flag: shunt current below lower limit |
| slow_clk_i | input | 1 | external slow timing clock (unused when internal divider selected) |
| ctrl_word_o | output | SECTIONS | section control word, 1 = section off |
| busy_o | output | 1 | high from acceptance until re-arm |
| slow_clk_o | output | 1 | slow clock level as seen by the sequencer |

## Verification
The main instance uses three sections and the external slow clock. The bench drives that clock by hand, which lets it place each event in either the high or the low phase. It then walks the word through every thermometer value, both saturation points and every combination of flags. A second instance selects the internal divider with HALF_DIV set to 8. This keeps a full slow period within a few dozen cycles, so the bench can measure the phase length and watch a write land inside a high phase.

// File: rtl/shunt_step_sequencer.sv
module shunt_step_sequencer #(
  parameter int SECTIONS = 3,
  parameter bit INT_SLOW = 1'b0,
  parameter int HALF_DIV = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                over_max_i,
  input  logic                under_min_i,
  input  logic                slow_clk_i,
  output logic [SECTIONS-1:0] ctrl_word_o,
  output logic                busy_o,
  output logic                slow_clk_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  typedef enum logic [1:0] {ARMED, WAIT_LOW, WAIT_RISE, WAIT_FALL} state_t;

  state_t              state;
  logic [1:0]          ov_s, un_s;
  logic                lvl, lvl_q;
  logic [SECTIONS-1:0] word, pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ov_s <= '0;
      un_s <= '0;
    end else begin
      ov_s <= {ov_s[0], over_max_i};
      un_s <= {un_s[0], under_min_i};
    end

  generate
    if (INT_SLOW) begin : g_div
      logic [CW-1:0] cnt;
      logic          div_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          cnt   <= '0;
          div_q <= 1'b0;
        end else if (cnt == CW'(HALF_DIV - 1)) begin
          cnt   <= '0;
          div_q <= ~div_q;
        end else begin
          cnt <= cnt + 1'b1;
        end
      assign lvl = div_q;
    end else begin : g_ext
      logic [1:0] sk;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sk <= '0;
        else        sk <= {sk[0], slow_clk_i};
      assign lvl = sk[1];
    end
  endgenerate

  wire rise = lvl & ~lvl_q;
  wire fall = ~lvl & lvl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ARMED;
      lvl_q <= 1'b0;
      word  <= '1;
      pend  <= '1;
    end else begin
      lvl_q <= lvl;
      case (state)
        ARMED:
          if (ov_s[1] | un_s[1]) begin
            pend  <= ov_s[1] ? {word[SECTIONS-2:0], 1'b1} : {1'b0, word[SECTIONS-1:1]};
            state <= lvl ? WAIT_LOW : WAIT_RISE;
          end
        WAIT_LOW:  if (!lvl) state <= WAIT_RISE;
        WAIT_RISE: if (rise) begin
                     word  <= pend;
                     state <= WAIT_FALL;
                   end
        WAIT_FALL: if (fall) state <= ARMED;
        default:   state <= ARMED;
      endcase
    end

  assign ctrl_word_o = word;
  assign busy_o      = (state != ARMED);
  assign slow_clk_o  = lvl;
endmodule

// File: rtl/shunt_step_sequencer_chk.sv
module shunt_step_sequencer_chk #(
  parameter int SECTIONS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SECTIONS-1:0] ctrl_word_o,
  input logic                busy_o,
  input logic                slow_clk_o
);
  wire [SECTIONS:0] wz = {1'b0, ctrl_word_o};

  assert_thermometer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((wz + 1'b1) & wz) == '0);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word_o != $past(ctrl_word_o)) |-> $countones(ctrl_word_o ^ $past(ctrl_word_o)) == 1);

  assert_write_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word_o != $past(ctrl_word_o)) |-> ($past(slow_clk_o) && !$past(slow_clk_o, 2)));

  assert_busy_at_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word_o != $past(ctrl_word_o)) |-> busy_o);

  assert_rearm_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (!$past(slow_clk_o) && $past(slow_clk_o, 2)));
endmodule

bind shunt_step_sequencer shunt_step_sequencer_chk #(.SECTIONS(SECTIONS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word_o(ctrl_word_o),
  .busy_o(busy_o), .slow_clk_o(slow_clk_o)
);

// File: tb/tb_shunt_step_sequencer.sv
module tb_shunt_step_sequencer;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ov = 1'b0, un = 1'b0, slow = 1'b0;
  logic ov2 = 1'b0, un2 = 1'b0;
  logic [2:0] word, word2;
  logic busy, busy2, slo, slo2;
  int total = 0, bad = 0;
  int n_on = 0;

  always #(PERIOD/2) clk = ~clk;

  shunt_step_sequencer #(.SECTIONS(3), .INT_SLOW(1'b0), .HALF_DIV(50)) dut (
    .clk(clk), .rst_n(rst_n), .over_max_i(ov), .under_min_i(un), .slow_clk_i(slow),
    .ctrl_word_o(word), .busy_o(busy), .slow_clk_o(slo));

  shunt_step_sequencer #(.SECTIONS(3), .INT_SLOW(1'b1), .HALF_DIV(8)) dut_div (
    .clk(clk), .rst_n(rst_n), .over_max_i(ov2), .under_min_i(un2), .slow_clk_i(1'b0),
    .ctrl_word_o(word2), .busy_o(busy2), .slow_clk_o(slo2));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int word_of(input int on);
    return (1 << (3 - on)) - 1;
  endfunction

  task automatic event_step(input bit o, input bit u, input bit hi);
    int old_w, exp_on;
    string tag;
    old_w = word_of(n_on);
    exp_on = o ? ((n_on > 0) ? n_on - 1 : 0) : ((n_on < 3) ? n_on + 1 : 3);
    if (o && u) tag = "R4";
    else if (exp_on == n_on) tag = "R5";
    else if (o) tag = "R2";
    else tag = "R3";
    slow = hi; wait_n(6);
    ov = o; un = u; wait_n(6);
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    check(word == old_w, "R6 no write before rise", word, old_w);
    ov = 1'b0; un = 1'b0;
    if (hi) begin
      slow = 1'b0; wait_n(6);
      check(word == old_w, "R6 no write in low phase", word, old_w);
    end
    slow = 1'b1; wait_n(6);
    n_on = exp_on;
    check(word == word_of(n_on), tag, word, word_of(n_on));
    check(busy == 1'b1, "R7 busy until fall", busy, 1);
    slow = 1'b0; wait_n(6);
    check(busy == 1'b0, "R7 rearm after fall", busy, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(4);
    check(word == 7, "R1 reset word", word, 7);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    rst_n = 1'b1;
    wait_n(4);
    check(word == 7 && busy == 1'b0, "R1 after release", word, 7);

    // R7: flag held across two slow periods gives one step per period
    un = 1'b1; wait_n(6);
    slow = 1'b1; wait_n(20);
    check(word == 3, "R7 one step in first period", word, 3);
    slow = 1'b0; wait_n(6);
    check(busy == 1'b1, "R7 rearmed and retaken", busy, 1);
    slow = 1'b1; wait_n(6);
    check(word == 1, "R7 one step in second period", word, 1);
    un = 1'b0;
    slow = 1'b0; wait_n(6);
    check(busy == 1'b0, "R7 idle after flag drop", busy, 0);
    n_on = 2;

    // R8: slow edges with no flags
    for (int k = 0; k < 3; k++) begin
      slow = 1'b1; wait_n(5);
      slow = 1'b0; wait_n(5);
      check(word == 1 && busy == 1'b0, "R8 idle edges", word, 1);
    end

    for (int i = 0; i < 4; i++) event_step(1'b0, 1'b1, i[0]);
    for (int i = 0; i < 4; i++) event_step(1'b1, 1'b0, i[0]);
    for (int i = 8; i < 32; i++) begin
      int c;
      c = i % 3;
      event_step(c != 0, c != 1, ((i / 3) % 2) == 1);
    end

    // R9: internal divider
    begin
      int hc, guard;
      guard = 0;
      while (slo2 != 1'b0 && guard < 100) begin wait_n(1); guard++; end
      while (slo2 != 1'b1 && guard < 100) begin wait_n(1); guard++; end
      hc = 0;
      while (slo2 == 1'b1 && hc < 100) begin wait_n(1); hc++; end
      check(hc == 8, "R9 divider half period", hc, 8);
      un2 = 1'b1;
      guard = 0;
      while (word2 == 3'd7 && guard < 200) begin wait_n(1); guard++; end
      check(word2 == 3, "R9 divided write word", word2, 3);
      check(slo2 == 1'b1, "R9 write in high phase", slo2, 1);
      un2 = 1'b0;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule